// File: doc/BRIEF.md
# Codec Power-Down and Clock-Mode Controller

This block decides when the digital core of a PCM voice codec is awake, and which clocking scheme it runs under. One input pin does two jobs. Held at a fixed level, it is a power-down control: a high level forces power-down and a low level allows power-up. Driven with a running clock, it becomes the separate receive master clock and selects asynchronous operation. The block synchronizes that pin to the transmit master clock, `clk`. It watches for edges within a programmable window of master-clock cycles to tell a level from a clock.

While the pin allows it, the core wakes on the rising edge of either frame sync. It falls back asleep once neither frame sync has produced a rising edge for a programmable number of master-clock cycles. The enable for the three-state PCM data output stays low after each wake-up until the second transmit frame-sync rising edge. The pulse that woke the core counts toward those two edges.

A state machine with four states holds the power status:
- `ST_OFF`: powered down.
- `ST_ARMED`: awake, no transmit frame sync seen yet.
- `ST_ONE_TX`: awake, one transmit frame sync seen.
- `ST_LIVE`: awake, data output enabled.

The machine has these transitions:
- wake-by-receive: `ST_OFF` to `ST_ARMED`, on a receive frame-sync rising edge alone.
- wake-by-transmit: `ST_OFF` to `ST_ONE_TX`, on a transmit frame-sync rising edge.
- first-tx: `ST_ARMED` to `ST_ONE_TX`.
- second-tx: `ST_ONE_TX` to `ST_LIVE`.
- sleep: any awake state to `ST_OFF`, taken when the pin is a static high or the inactivity timer has expired. Sleep has priority over every other transition.

Top module: `codec_pwr_ctl`

## Requirements
- R1: While `por_n` is low, and on release until a wake-up, `pdn` is 1, `dx_oe` is 0 and `async_mode` is 0.
- R2: With `mclkr_pdn` static low, the clock edge at which `fsx` is first sampled high (after having been sampled low) clears `pdn`.
- R3: A rising edge on `fsr` alone also clears `pdn`, and it leaves `dx_oe` at 0.
- R4: Once `mclkr_pdn` has been sampled high for ACT_WIN+6 consecutive cycles, `pdn` is 1. Frame-sync pulses then do not clear it.
- R5: When neither frame sync has had a rising edge for IDLE_CYC+3 cycles, `pdn` is 1. Pulses spaced less than IDLE_CYC-4 cycles apart keep `pdn` at 0.
- R6: After a wake-up, `dx_oe` rises at the clock edge of the second `fsx` rising edge, counting the edge that caused the wake-up, and not before.
- R7: `async_mode` is 0 once `mclkr_pdn` has held one level for ACT_WIN+6 cycles. It is 1 while the pin shows an edge at least every ACT_WIN cycles, and the pin then does not cause power-down.
- R8: `dx_oe` is never 1 while `pdn` is 1. Entering power-down clears `dx_oe` at the same clock edge.
- R9: A frame sync held high continuously counts as one rising edge only, so it does not hold off power-down beyond IDLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit master clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mclkr_pdn | input | 1 | Shared pin: static power-down level or receive master clock |
| fsx | input | 1 | Transmit frame sync, synchronous to clk |
| fsr | input | 1 | Receive frame sync, synchronous to clk |
| pdn | output | 1 | 1 while the core is powered down |
| dx_oe | output | 1 | Enable gate for the three-state PCM data output |
| async_mode | output | 1 | 1 selects asynchronous clocking, 0 synchronous |

## Verification
The assertions take both frame syncs to be synchronous to `clk` and to stay stable around its rising edge. They take the shared pin either to change only between edges or to be a clock much slower than `clk`, so that a synchronized edge is never lost. The stimulus changes every input only on the falling edge of `clk`. It toggles the shared pin every three cycles when it plays a clock. It always keeps a frame sync low for at least one cycle between pulses, except in the deliberately held-high case.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ONE_TX = 2'd2,
        ST_LIVE   = 2'd3
    } cpc_state_e;

endpackage

// File: rtl/cpc_pin_sense.sv
module cpc_pin_sense #(
    parameter int ACT_WIN     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin,
    output logic toggling,
    output logic pin_level
);
    localparam int AW = (ACT_WIN > 2) ? $clog2(ACT_WIN) : 1;
    localparam logic [AW-1:0] WIN_LAST = AW'(ACT_WIN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic [AW-1:0]          win_cnt;
    logic                   tog_q;
    logic                   edge_seen;

    // synchronizer chain, reset to the power-down level
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q <= '1;
                else        sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

    // window counter: an edge restarts it, a full quiet window declares static
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            win_cnt <= '0;
            tog_q   <= 1'b0;
        end else if (edge_seen) begin
            win_cnt <= '0;
            tog_q   <= 1'b1;
        end else if (win_cnt == WIN_LAST) begin
            tog_q   <= 1'b0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assign toggling  = tog_q;
    assign pin_level = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cpc_fs_watch.sv
module cpc_fs_watch #(
    parameter int IDLE_CYC = 4096
) (
    input  logic clk,
    input  logic por_n,
    input  logic fsx,
    input  logic fsr,
    output logic tx_rise,
    output logic any_rise,
    output logic idle
);
    localparam int IW = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

    logic          fsx_q;
    logic          fsr_q;
    logic [IW-1:0] gap_cnt;
    logic          idle_q;
    logic          rx_rise;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fsx_q <= 1'b0;
            fsr_q <= 1'b0;
        end else begin
            fsx_q <= fsx;
            fsr_q <= fsr;
        end
    end

    assign tx_rise  = fsx & ~fsx_q;
    assign rx_rise  = fsr & ~fsr_q;
    assign any_rise = tx_rise | rx_rise;

    // inactivity timer: starts expired, any frame-sync rise restarts it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            gap_cnt <= '0;
            idle_q  <= 1'b1;
        end else if (any_rise) begin
            gap_cnt <= '0;
            idle_q  <= 1'b0;
        end else if (!idle_q) begin
            if (gap_cnt == IDLE_LAST) idle_q <= 1'b1;
            else                      gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign idle = idle_q;

endmodule

// File: rtl/cpc_fsm.sv
module cpc_fsm
    import cpc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic hold_off,
    input  logic idle,
    input  logic tx_rise,
    input  logic any_rise,
    output logic pdn,
    output logic dx_oe
);
    cpc_state_e state_q;
    cpc_state_e state_d;
    logic       go_sleep;

    assign go_sleep = hold_off | (idle & ~any_rise);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!hold_off && any_rise)
                    state_d = tx_rise ? ST_ONE_TX : ST_ARMED;
            end
            ST_ARMED: begin
                if (go_sleep)     state_d = ST_OFF;
                else if (tx_rise) state_d = ST_ONE_TX;
            end
            ST_ONE_TX: begin
                if (go_sleep)     state_d = ST_OFF;
                else if (tx_rise) state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (go_sleep)     state_d = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        pdn   = 1'b1;
        dx_oe = 1'b0;
        unique case (state_q)
            ST_OFF:    begin pdn = 1'b1; dx_oe = 1'b0; end
            ST_ARMED:  begin pdn = 1'b0; dx_oe = 1'b0; end
            ST_ONE_TX: begin pdn = 1'b0; dx_oe = 1'b0; end
            ST_LIVE:   begin pdn = 1'b0; dx_oe = 1'b1; end
        endcase
    end

endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl #(
    parameter int ACT_WIN     = 64,
    parameter int IDLE_CYC    = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic mclkr_pdn,
    input  logic fsx,
    input  logic fsr,
    output logic pdn,
    output logic dx_oe,
    output logic async_mode
);
    logic toggling;
    logic pin_level;
    logic tx_rise;
    logic any_rise;
    logic idle;
    logic hold_off;

    cpc_pin_sense #(
        .ACT_WIN    (ACT_WIN),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk      (clk),
        .por_n    (por_n),
        .pin      (mclkr_pdn),
        .toggling (toggling),
        .pin_level(pin_level)
    );

    cpc_fs_watch #(
        .IDLE_CYC(IDLE_CYC)
    ) u_watch (
        .clk     (clk),
        .por_n   (por_n),
        .fsx     (fsx),
        .fsr     (fsr),
        .tx_rise (tx_rise),
        .any_rise(any_rise),
        .idle    (idle)
    );

    // a static high on the shared pin is a power-down request
    assign hold_off = ~toggling & pin_level;

    cpc_fsm u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .hold_off(hold_off),
        .idle    (idle),
        .tx_rise (tx_rise),
        .any_rise(any_rise),
        .pdn     (pdn),
        .dx_oe   (dx_oe)
    );

    assign async_mode = toggling;

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int ACT_WIN  = 64,
    parameter int IDLE_CYC = 4096
) (
    input logic clk,
    input logic por_n,
    input logic mclkr_pdn,
    input logic fsx,
    input logic fsr,
    input logic pdn,
    input logic dx_oe,
    input logic async_mode
);
    localparam int LIM = ((IDLE_CYC > ACT_WIN) ? IDLE_CYC : ACT_WIN) + 8;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIM);

    logic          fx1, fr1, pin1;
    logic          rose_any;
    logic [CW-1:0] gap_c, hi_c, lvl_c;

    assign rose_any = (fsx & ~fx1) | (fsr & ~fr1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fx1   <= 1'b0;
            fr1   <= 1'b0;
            pin1  <= 1'b1;
            gap_c <= CMAX;
            hi_c  <= '0;
            lvl_c <= '0;
        end else begin
            fx1  <= fsx;
            fr1  <= fsr;
            pin1 <= mclkr_pdn;
            if (rose_any)          gap_c <= '0;
            else if (gap_c != CMAX) gap_c <= gap_c + 1'b1;
            if (!mclkr_pdn)        hi_c <= '0;
            else if (hi_c != CMAX) hi_c <= hi_c + 1'b1;
            if (mclkr_pdn != pin1)  lvl_c <= '0;
            else if (lvl_c != CMAX) lvl_c <= lvl_c + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !por_n |-> (pdn && !dx_oe && !async_mode));

    assert_wake_on_rise_R2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pdn) |-> $past(rose_any));

    assert_static_high_off_R4: assert property (@(posedge clk) disable iff (!por_n)
        (hi_c >= CW'(ACT_WIN + 6)) |-> pdn);

    assert_idle_timeout_R5: assert property (@(posedge clk) disable iff (!por_n)
        (gap_c >= CW'(IDLE_CYC + 3)) |-> pdn);

    assert_second_tx_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(dx_oe) |-> ($past(fsx) && !$past(fsx, 2)));

    assert_static_sync_R7: assert property (@(posedge clk) disable iff (!por_n)
        (lvl_c >= CW'(ACT_WIN + 6)) |-> !async_mode);

    assert_oe_gated_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pdn) |-> !dx_oe);

endmodule

bind codec_pwr_ctl cpc_checker #(
    .ACT_WIN (ACT_WIN),
    .IDLE_CYC(IDLE_CYC)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .mclkr_pdn (mclkr_pdn),
    .fsx       (fsx),
    .fsr       (fsr),
    .pdn       (pdn),
    .dx_oe     (dx_oe),
    .async_mode(async_mode)
);

// File: tb/sim_codec_pwr_ctl.sv
`timescale 1ns/1ps
module sim_codec_pwr_ctl;
    localparam int AW = 8;
    localparam int IC = 64;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic pin = 1'b1;
    logic fsx = 1'b0;
    logic fsr = 1'b0;
    logic pdn, dx_oe, async_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    codec_pwr_ctl #(.ACT_WIN(AW), .IDLE_CYC(IC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .por_n(por_n), .mclkr_pdn(pin), .fsx(fsx), .fsr(fsr),
        .pdn(pdn), .dx_oe(dx_oe), .async_mode(async_mode)
    );

    function automatic bit exp_oe(int ntx);
        return ntx >= 2;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        fsx = 1'b1;
        @(negedge clk);
        fsx = 1'b0;
    endtask

    task automatic pulse_rx();
        fsr = 1'b1;
        @(negedge clk);
        fsr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ntx;
        bit up;
        int r;
        r = $urandom(32'h5eed);

        // R1 reset state
        idle_n(3);
        chk("R1 pdn in reset", pdn, 1'b1);
        chk("R1 oe in reset", dx_oe, 1'b0);
        chk("R1 async in reset", async_mode, 1'b0);
        por_n = 1'b1;
        idle_n(AW + 10);
        chk("R1 pdn after release", pdn, 1'b1);

        // R4 static high ignores frame syncs
        pulse_tx();
        chk("R4 fsx ignored while pin high", pdn, 1'b1);
        idle_n(2);
        pulse_rx();
        chk("R4 fsr ignored while pin high", pdn, 1'b1);

        // R7 static low is synchronous mode
        pin = 1'b0;
        idle_n(3 * AW);
        chk("R7 static low sync", async_mode, 1'b0);
        chk("R2 no pulse no wake", pdn, 1'b1);

        // R3 receive sync wakes, output stays off
        pulse_rx();
        chk("R3 fsr wakes", pdn, 1'b0);
        chk("R3 oe off", dx_oe, 1'b0);
        idle_n(5);
        pulse_rx();
        chk("R3 oe off after 2nd fsr", dx_oe, 1'b0);
        idle_n(5);
        pulse_tx();
        chk("R6 oe off after 1st fsx", dx_oe, 1'b0);
        idle_n(10);
        pulse_tx();
        chk("R6 oe on at 2nd fsx", dx_oe, 1'b1);

        // R5 spacing keeps awake, silence sleeps
        idle_n(IC - 10);
        chk("R5 awake before timeout", pdn, 1'b0);
        pulse_rx();
        idle_n(IC - 10);
        chk("R5 awake after spaced pulse", pdn, 1'b0);
        idle_n(16);
        chk("R5 asleep after timeout", pdn, 1'b1);
        chk("R8 oe off when asleep", dx_oe, 1'b0);

        // R2 wake by transmit counts as first
        pulse_tx();
        chk("R2 fsx wakes", pdn, 1'b0);
        chk("R6 oe off after waking fsx", dx_oe, 1'b0);
        idle_n(7);
        pulse_tx();
        chk("R6 oe on after 2nd fsx", dx_oe, 1'b1);

        // R4 pin high forces power-down
        pin = 1'b1;
        idle_n(AW + 8);
        chk("R4 pin high sleeps", pdn, 1'b1);
        chk("R8 oe cleared", dx_oe, 1'b0);

        // R7 running clock selects async and does not hold off
        for (int c = 0; c < 80; c++) begin
            if (c % 3 == 0) pin = ~pin;
            if (c % 20 == 5) fsx = 1'b1; else fsx = 1'b0;
            @(negedge clk);
        end
        fsx = 1'b0;
        chk("R7 toggling async", async_mode, 1'b1);
        chk("R7 awake while toggling", pdn, 1'b0);
        chk("R6 oe on while toggling", dx_oe, 1'b1);
        pin = 1'b0;
        idle_n(AW + 8);
        chk("R7 back to sync", async_mode, 1'b0);

        // R9 held-high sync counts once
        fsx = 1'b1;
        idle_n(IC + 10);
        chk("R9 held fsx sleeps", pdn, 1'b1);
        fsx = 1'b0;
        idle_n(3);

        // random frame-sync traffic, state predicted by bench model
        up = 1'b0;
        ntx = 0;
        for (int i = 0; i < 60; i++) begin
            if (($urandom % 2) == 0) begin
                pulse_tx();
                ntx++;
            end else begin
                pulse_rx();
            end
            up = 1'b1;
            chk("R2 random wake", pdn, 1'b0);
            chk("R6 random gate", dx_oe, exp_oe(ntx));
            if (($urandom % 5) == 0) begin
                idle_n(IC + 8 + ($urandom % 8));
                up = 1'b0;
                ntx = 0;
                chk("R5 random timeout", pdn, ~up);
                chk("R8 random oe off", dx_oe, 1'b0);
            end else begin
                idle_n(1 + ($urandom % (IC - 10)));
                chk("R5 random stays up", pdn, 1'b0);
            end
        end

        finish_run();
    end
endmodule